// File: doc/BRIEF.md
# Write-Through Valid/Invalid Snoop Controller

This block keeps coherence state for a write-through, write no-allocate cache that sits on a shared broadcast bus. Each tracked line has one valid bit and a tag. The lines live in a small direct-mapped array indexed by the low bits of a line address. The processor side presents one request at a time: a load, a store or an evict, together with a line address. The controller says whether a load hits. When a request needs the bus, it raises a bus request and holds the processor stalled until the grant arrives.

On the bus side the controller issues reads for load misses and writes for every store. It also watches the writes that other caches put on the bus. A snooped write from another requester to a line held valid here removes that line. Any number of caches may keep the same line valid, so snooped reads change nothing. Each bus transaction carries the requester's ID, and the controller ignores snooped traffic that carries its own ID. Data storage, memory timing and arbitration are outside the block. Arbitration appears only as a grant input.

Top module: `wt_snoop_ctrl`

## Requirements
- R1: After reset every line is invalid, so the first load to any address needs the bus. With no request present, `req_ready`, `bus_req` and `bus_out_valid` are low.
- R2: A load whose line is not valid with a matching tag raises `bus_req` and keeps `req_ready` low while `bus_grant` is low. In the cycle `bus_grant` is high, it drives `bus_out_valid` high, `bus_out_wr` low, `bus_out_addr` equal to the request address and `bus_out_id` equal to `MY_ID`, and `req_ready` goes high.
- R3: After a load miss completes, the line is valid. A later load to that address completes in its first cycle with `load_hit` and `req_ready` high and `bus_req` low.
- R4: Request codes are load = 0, store = 1 and evict = 2 on `req_op`. A store always raises `bus_req` and, on grant, issues a bus write (`bus_out_wr` high) to the request address. It leaves the line's state unchanged: an invalid line stays invalid and a valid line stays valid.
- R5: A snooped bus write (`snoop_wr` high) whose `snoop_id` differs from `MY_ID` and whose address matches a valid line invalidates that line.
- R6: Some snooped traffic leaves the line's state unchanged: a write carrying `MY_ID`, and a write whose tag differs from the stored tag at the same index.
- R7: An evict completes in its first cycle with no bus request and invalidates the line if its tag matches. An evict of a line that is not present also completes without bus traffic.
- R8: The array is direct-mapped on the low `IDX_W` address bits. A load fill replaces whatever line was held at that index, so the old address then misses.
- R9: When a snoop and a local request arrive in the same cycle, the snoop is applied first. A load to a line that the same-cycle snoop invalidates is a miss and goes to the bus. The fill from that miss then leaves the line valid.
- R10: A snooped bus read (`snoop_wr` low) from another requester leaves a valid line valid, because several caches may share a line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request present, held until `req_ready` |
| req_op | input | 2 | 0 load, 1 store, 2 evict |
| req_addr | input | ADDR_W | Line address of the request |
| req_ready | output | 1 | Request completes this cycle |
| load_hit | output | 1 | Load found a valid matching line |
| bus_req | output | 1 | Bus needed for the current request |
| bus_grant | input | 1 | Bus granted this cycle |
| bus_out_valid | output | 1 | Transaction driven on the bus this cycle |
| bus_out_wr | output | 1 | 1 write, 0 read |
| bus_out_addr | output | ADDR_W | Transaction line address |
| bus_out_id | output | ID_W | Requester ID, always `MY_ID` |
| snoop_valid | input | 1 | A bus transaction is visible |
| snoop_wr | input | 1 | Observed transaction is a write |
| snoop_addr | input | ADDR_W | Observed line address |
| snoop_id | input | ID_W | Observed requester ID |

## Verification
A snooped invalidation and a local load can hit the same line in one clock. The bench provokes this by driving a foreign write and a load to the same valid address on the same edge. Snoop-first order is judged by `load_hit` staying low and `bus_req` rising in that cycle. A follow-up load must then hit, which shows that the fill took effect after the invalidation. The bench also overlaps a store with a stalled grant and applies snoops that must be ignored. For each ignored snoop it checks the line's survival at the ports with a later load.

// File: rtl/wt_snoop_ctrl.sv
module wt_snoop_ctrl #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned ID_W   = 2,
  parameter logic [ID_W-1:0] MY_ID = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              load_hit,
  output logic              bus_req,
  input  logic              bus_grant,
  output logic              bus_out_valid,
  output logic              bus_out_wr,
  output logic [ADDR_W-1:0] bus_out_addr,
  output logic [ID_W-1:0]   bus_out_id,
  input  logic              snoop_valid,
  input  logic              snoop_wr,
  input  logic [ADDR_W-1:0] snoop_addr,
  input  logic [ID_W-1:0]   snoop_id
);
  localparam int unsigned LINES = 1 << IDX_W;
  localparam int unsigned TAG_W = ADDR_W - IDX_W;
  localparam logic [1:0] OP_LD = 2'd0;
  localparam logic [1:0] OP_ST = 2'd1;
  localparam logic [1:0] OP_EV = 2'd2;

  logic [LINES-1:0] vld;
  logic [TAG_W-1:0] tags [LINES];

  wire [IDX_W-1:0] r_idx = req_addr[IDX_W-1:0];
  wire [TAG_W-1:0] r_tag = req_addr[ADDR_W-1:IDX_W];
  wire [IDX_W-1:0] s_idx = snoop_addr[IDX_W-1:0];
  wire [TAG_W-1:0] s_tag = snoop_addr[ADDR_W-1:IDX_W];

  wire snoop_kill = snoop_valid && snoop_wr && (snoop_id != MY_ID)
                    && vld[s_idx] && (tags[s_idx] == s_tag);
  wire r_present  = vld[r_idx] && (tags[r_idx] == r_tag)
                    && !(snoop_kill && (s_idx == r_idx));

  wire is_ld = (req_op == OP_LD);
  wire is_st = (req_op == OP_ST);
  wire is_ev = (req_op == OP_EV);

  wire need_bus = req_valid && (is_st || (is_ld && !r_present));
  wire fill     = need_bus && bus_grant && is_ld;
  wire drop     = req_valid && is_ev && r_present;

  assign bus_req       = need_bus;
  assign bus_out_valid = need_bus && bus_grant;
  assign bus_out_wr    = is_st;
  assign bus_out_addr  = req_addr;
  assign bus_out_id    = MY_ID;
  assign req_ready     = req_valid && (!need_bus || bus_grant);
  assign load_hit      = req_valid && is_ld && r_present;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
    end else begin
      if (snoop_kill) vld[s_idx] <= 1'b0;
      if (drop)       vld[r_idx] <= 1'b0;
      if (fill)       vld[r_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill) tags[r_idx] <= r_tag;
  end
endmodule

module wt_snoop_ctrl_chk #(
  parameter int unsigned ID_W = 2,
  parameter logic [ID_W-1:0] MY_ID = '0
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic [1:0]      req_op,
  input logic            req_ready,
  input logic            load_hit,
  input logic            bus_req,
  input logic            bus_grant,
  input logic            bus_out_valid,
  input logic            bus_out_wr,
  input logic [ID_W-1:0] bus_out_id
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !req_ready && !bus_req && !bus_out_valid);
  // R2
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_grant |-> !req_ready);
  // R2
  issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_out_valid |-> bus_grant && bus_req && req_ready && bus_out_id == MY_ID);
  // R2
  read_from_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_out_valid && !bus_out_wr |-> req_op == 2'd0);
  // R3
  hit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_hit |-> !bus_req && req_ready);
  // R4
  store_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_op == 2'd1 |-> bus_req && !load_hit);
  // R7
  evict_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_op == 2'd2 |-> req_ready && !bus_req);
endmodule

bind wt_snoop_ctrl wt_snoop_ctrl_chk #(.ID_W(ID_W), .MY_ID(MY_ID)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
  .req_ready(req_ready), .load_hit(load_hit), .bus_req(bus_req),
  .bus_grant(bus_grant), .bus_out_valid(bus_out_valid),
  .bus_out_wr(bus_out_wr), .bus_out_id(bus_out_id)
);

// File: tb/test_wt_snoop_ctrl.sv
module test_wt_snoop_ctrl;
  localparam int CLK_P = 10;
  localparam logic [1:0] LD = 2'd0, ST = 2'd1, EV = 2'd2;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0;
  logic [1:0] req_op = 0;
  logic [15:0] req_addr = 0;
  logic req_ready, load_hit, bus_req, bus_out_valid, bus_out_wr;
  logic bus_grant = 0;
  logic [15:0] bus_out_addr;
  logic [1:0] bus_out_id;
  logic snoop_valid = 0, snoop_wr = 0;
  logic [15:0] snoop_addr = 0;
  logic [1:0] snoop_id = 0;
  int total = 0, bad = 0;
  bit done = 0;

  wt_snoop_ctrl i_wt_snoop_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_ready(req_ready), .load_hit(load_hit),
    .bus_req(bus_req), .bus_grant(bus_grant), .bus_out_valid(bus_out_valid),
    .bus_out_wr(bus_out_wr), .bus_out_addr(bus_out_addr), .bus_out_id(bus_out_id),
    .snoop_valid(snoop_valid), .snoop_wr(snoop_wr), .snoop_addr(snoop_addr),
    .snoop_id(snoop_id)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic expect_hit(logic [15:0] a, string tag);
    @(negedge clk);
    req_valid = 1; req_op = LD; req_addr = a;
    #1;
    check({tag, " load_hit"}, load_hit, 1);
    check({tag, " bus_req"}, bus_req, 0);
    check({tag, " ready"}, req_ready, 1);
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  task automatic bus_access(logic [1:0] op, logic [15:0] a, int waits, string tag);
    @(negedge clk);
    req_valid = 1; req_op = op; req_addr = a; bus_grant = 0;
    #1;
    check({tag, " bus_req"}, bus_req, 1);
    check({tag, " no hit"}, load_hit, 0);
    for (int i = 0; i < waits; i++) begin
      check({tag, " stalled ready"}, req_ready, 0);
      check({tag, " no bus_out"}, bus_out_valid, 0);
      @(negedge clk); #1;
    end
    bus_grant = 1;
    #1;
    check({tag, " ready on grant"}, req_ready, 1);
    check({tag, " bus_out_valid"}, bus_out_valid, 1);
    check({tag, " bus_out_wr"}, bus_out_wr, op == ST);
    check({tag, " bus_out_addr"}, bus_out_addr, a);
    check({tag, " bus_out_id"}, bus_out_id, 0);
    @(posedge clk); #1;
    req_valid = 0; bus_grant = 0;
  endtask

  task automatic snoop(logic wr, logic [1:0] id, logic [15:0] a);
    @(negedge clk);
    snoop_valid = 1; snoop_wr = wr; snoop_id = id; snoop_addr = a;
    @(posedge clk); #1;
    snoop_valid = 0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 idle ready", req_ready, 0);
    check("R1 idle bus_req", bus_req, 0);
    check("R1 idle bus_out", bus_out_valid, 0);
    bus_access(LD, 16'h0013, 0, "R1 first load");
  endtask

  task automatic t_load();
    bus_access(LD, 16'h0025, 3, "R2 load miss");
    expect_hit(16'h0025, "R3 reload");
  endtask

  task automatic t_store();
    bus_access(ST, 16'h0046, 2, "R4 store invalid");
    bus_access(LD, 16'h0046, 0, "R4 still invalid");
    bus_access(ST, 16'h0025, 1, "R4 store valid");
    expect_hit(16'h0025, "R4 stays valid");
  endtask

  task automatic t_snoop();
    snoop(1, 2'd2, 16'h0025);
    bus_access(LD, 16'h0025, 0, "R5 invalidated");
    snoop(1, 2'd0, 16'h0025);
    expect_hit(16'h0025, "R6 own id");
    snoop(1, 2'd3, 16'h0125);
    expect_hit(16'h0025, "R6 other tag");
    snoop(0, 2'd2, 16'h0025);
    expect_hit(16'h0025, "R10 shared read");
  endtask

  task automatic t_evict();
    @(negedge clk);
    req_valid = 1; req_op = EV; req_addr = 16'h0025;
    #1;
    check("R7 evict ready", req_ready, 1);
    check("R7 evict bus_req", bus_req, 0);
    @(posedge clk); #1; req_valid = 0;
    bus_access(LD, 16'h0025, 0, "R7 gone");
    @(negedge clk);
    req_valid = 1; req_op = EV; req_addr = 16'h0777;
    #1;
    check("R7 absent evict ready", req_ready, 1);
    check("R7 absent evict bus_req", bus_req, 0);
    @(posedge clk); #1; req_valid = 0;
    expect_hit(16'h0025, "R7 unrelated line kept");
  endtask

  task automatic t_conflict();
    bus_access(LD, 16'h0A25, 0, "R8 same index");
    expect_hit(16'h0A25, "R8 new line");
    bus_access(LD, 16'h0025, 0, "R8 old replaced");
  endtask

  task automatic t_race();
    @(negedge clk);
    snoop_valid = 1; snoop_wr = 1; snoop_id = 2'd1; snoop_addr = 16'h0025;
    req_valid = 1; req_op = LD; req_addr = 16'h0025; bus_grant = 0;
    #1;
    check("R9 race no hit", load_hit, 0);
    check("R9 race bus_req", bus_req, 1);
    check("R9 race stalled", req_ready, 0);
    bus_grant = 1;
    #1;
    check("R9 race ready", req_ready, 1);
    @(posedge clk); #1;
    snoop_valid = 0; req_valid = 0; bus_grant = 0;
    expect_hit(16'h0025, "R9 fill after snoop");
  endtask

  initial begin
    #(CLK_P * 100000);
    total++; bad++;
    $display("FAIL watchdog: actual=1 expected=0");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk); rst_n = 1;
    t_reset();
    t_load();
    t_store();
    t_snoop();
    t_evict();
    t_conflict();
    t_race();
    repeat (2) @(posedge clk);
    finish_run();
  end
endmodule